// File: doc/BRIEF.md
# Home-Node Cache Directory Controller

This block is the directory logic at the home node of a directory-based, cache-coherent, distributed-memory multiprocessor. Each node owns a slice of the physical memory and keeps one directory entry for each line in that slice. An entry records whether the line is cached anywhere and, if so, which single node holds it. A line may live in at most one cache at a time.

A request message arrives from the interconnect. It names the requesting node and a local line index. The block looks up the entry for that line. If the line is uncached, or is already held by the requester, the block reads the line from local memory and returns it. If another node holds the line, the block first sends a recall to that holder. It waits for the acknowledgement, which carries the line data, and forwards that data to the requester. Finally the entry is rewritten so that it names the requester as owner.

Only one request is served at a time. The block has six states:
- IDLE: ready for a request.
- LOOKUP: read the entry.
- MEM_READ: wait for local memory.
- RECALL_WAIT: send the recall and wait for the acknowledgement.
- REPLY: offer the reply until it is taken.
- UPDATE: write the entry.

The transitions are:
- IDLE to LOOKUP when a request is accepted.
- LOOKUP to MEM_READ when the line is uncached or held by the requester.
- LOOKUP to RECALL_WAIT when another node holds the line.
- MEM_READ to REPLY when memory answers.
- RECALL_WAIT to REPLY when the acknowledgement arrives after the recall has been accepted.
- REPLY to UPDATE when the reply is taken.
- UPDATE to IDLE.

Top module: `home_dir_ctrl`

## Requirements
- R1: After reset, req_ready is 1 and mem_req, rcl_valid and rsp_valid are 0. Every directory entry reads as uncached, so the first request to any line causes a memory read and no recall.
- R2: A request for an uncached line raises mem_req with mem_line equal to the requested index. It then produces one reply carrying the requester node, the same line index and the data returned on mem_rsp_data.
- R3: After an uncached line is granted, the entry names the requester as owner. A later request for that line from a different node recalls it from that requester.
- R4: A request for a line held by a different node sends one recall. The recall carries rcl_node equal to the holder and rcl_line equal to the index, and no memory read happens for that request. The reply data equals the data on rcl_ack_data.
- R5: After a recall-based grant, the entry names the new requester, so the next request from a third node recalls from that requester.
- R6: A request from the node already recorded as owner is served by a memory read with no recall, and the entry is left unchanged. A following request from another node still recalls from that same owner.
- R7: req_ready is 0 from the cycle after a request is accepted until the directory update has finished. The reply is held with unchanged fields while rsp_ready is 0. After the reply is taken, req_ready returns to 1 exactly two clock edges later.
- R8: rcl_valid and its fields stay unchanged while rcl_ready is 0, and rcl_valid drops after the recall is accepted. mem_req and rcl_valid are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request message present |
| req_ready | output | 1 | Block can accept a request (high only when idle) |
| req_node | input | NODE_W | Requesting node number |
| req_line | input | IDX_W | Local line index requested |
| mem_req | output | 1 | Local memory read in progress |
| mem_line | output | IDX_W | Line index being read |
| mem_rsp_valid | input | 1 | Memory read data present |
| mem_rsp_data | input | DATA_W | Line data from local memory |
| rcl_valid | output | 1 | Recall message to the current holder |
| rcl_ready | input | 1 | Recall message accepted |
| rcl_node | output | NODE_W | Node being recalled from |
| rcl_line | output | IDX_W | Line being recalled |
| rcl_ack_valid | input | 1 | Recall acknowledgement with data |
| rcl_ack_data | input | DATA_W | Line data returned by the old holder |
| rsp_valid | output | 1 | Reply message present |
| rsp_ready | input | 1 | Reply message taken |
| rsp_node | output | NODE_W | Destination node of the reply |
| rsp_line | output | IDX_W | Line index of the reply |
| rsp_data | output | DATA_W | Line data of the reply |

## Verification
The bench builds the block with its defaults: 8-bit node numbers, 512-bit lines, and a 6-bit line index, which gives a 64-entry directory in place of the full slice. With so few entries, the directed cases can reach both the first and the last index. Random requests are drawn from eight lines and five nodes, including node 255. This keeps ownership changes, same-owner repeats and back-to-back recalls frequent. Memory, recall and reply handshakes are given random stalls, so the hold-while-stalled rules are exercised against a reference directory kept in the bench.

// File: rtl/hdc_pkg.sv
package hdc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_MEM_READ,
        ST_RECALL_WAIT,
        ST_REPLY,
        ST_UPDATE
    } hdc_state_t;
endpackage

// File: rtl/hdc_dir_table.sv
module hdc_dir_table #(
    parameter int NODE_W = 8,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_cached,
    output logic [NODE_W-1:0] rd_owner,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [NODE_W-1:0] wr_owner
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] cached_q;
    logic [NODE_W-1:0] owner_q [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cached_q[e] <= 1'b0;
                owner_q[e]  <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(e))) begin
                cached_q[e] <= 1'b1;
                owner_q[e]  <= wr_owner;
            end
        end
    end

    assign rd_cached = cached_q[rd_idx];
    assign rd_owner  = owner_q[rd_idx];

    // R3
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cached_q[$past(wr_idx)] && owner_q[$past(wr_idx)] == $past(wr_owner)));
endmodule

// File: rtl/hdc_line_buf.sv
module hdc_line_buf #(
    parameter int DATA_W = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_mem,
    input  logic [DATA_W-1:0] mem_data,
    input  logic              ld_ack,
    input  logic [DATA_W-1:0] ack_data,
    output logic [DATA_W-1:0] data_o
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_o <= '0;
        else if (ld_mem)
            data_o <= mem_data;
        else if (ld_ack)
            data_o <= ack_data;
    end

    // R4
    one_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ld_mem, ld_ack}));
    // R7
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_mem && !ld_ack) |=> $stable(data_o));
endmodule

// File: rtl/hdc_fsm.sv
module hdc_fsm
    import hdc_pkg::*;
#(
    parameter int NODE_W = 8,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [NODE_W-1:0] req_node,
    input  logic [IDX_W-1:0]  req_line,
    input  logic              ent_cached,
    input  logic [NODE_W-1:0] ent_owner,
    output logic              mem_req,
    input  logic              mem_rsp_valid,
    output logic              rcl_valid,
    input  logic              rcl_ready,
    output logic [NODE_W-1:0] rcl_node,
    input  logic              rcl_ack_valid,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [NODE_W-1:0] cur_node,
    output logic [IDX_W-1:0]  cur_line,
    output logic              ld_mem,
    output logic              ld_ack,
    output logic              wr_en
);
    hdc_state_t state_q, state_d;
    logic [NODE_W-1:0] node_q, holder_q;
    logic [IDX_W-1:0]  line_q;
    logic              pend_q, keep_q;
    logic              take_req, remote_held;

    assign take_req    = (state_q == ST_IDLE) && req_valid;
    assign remote_held = ent_cached && (ent_owner != node_q);

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            node_q   <= '0;
            line_q   <= '0;
            holder_q <= '0;
            pend_q   <= 1'b0;
            keep_q   <= 1'b0;
        end else begin
            if (take_req) begin
                node_q <= req_node;
                line_q <= req_line;
            end
            if (state_q == ST_LOOKUP) begin
                holder_q <= ent_owner;
                pend_q   <= remote_held;
                keep_q   <= ent_cached && (ent_owner == node_q);
            end else if (pend_q && rcl_ready) begin
                pend_q <= 1'b0;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:        if (req_valid) state_d = ST_LOOKUP;
            ST_LOOKUP:      state_d = remote_held ? ST_RECALL_WAIT : ST_MEM_READ;
            ST_MEM_READ:    if (mem_rsp_valid) state_d = ST_REPLY;
            ST_RECALL_WAIT: if (!pend_q && rcl_ack_valid) state_d = ST_REPLY;
            ST_REPLY:       if (rsp_ready) state_d = ST_UPDATE;
            ST_UPDATE:      state_d = ST_IDLE;
            default:        state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready = 1'b0;
        mem_req   = 1'b0;
        rcl_valid = 1'b0;
        rsp_valid = 1'b0;
        ld_mem    = 1'b0;
        ld_ack    = 1'b0;
        wr_en     = 1'b0;
        unique case (state_q)
            ST_IDLE:        req_ready = 1'b1;
            ST_LOOKUP:      ;
            ST_MEM_READ: begin
                mem_req = 1'b1;
                ld_mem  = mem_rsp_valid;
            end
            ST_RECALL_WAIT: begin
                rcl_valid = pend_q;
                ld_ack    = !pend_q && rcl_ack_valid;
            end
            ST_REPLY:       rsp_valid = 1'b1;
            ST_UPDATE:      wr_en = !keep_q;
            default:        ;
        endcase
    end

    assign rcl_node = holder_q;
    assign cur_node = node_q;
    assign cur_line = line_q;

    // R7
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    // R7
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(cur_node) && $stable(cur_line)));
    // R8
    rcl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rcl_valid && !rcl_ready) |=> (rcl_valid && $stable(rcl_node) && $stable(cur_line)));
    // R8
    rcl_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rcl_valid && rcl_ready) |=> !rcl_valid);
    // R8
    src_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && rcl_valid));
    // R4
    rcl_not_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rcl_valid |-> (rcl_node != cur_node));
    // R6
    keep_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(state_q == ST_REPLY)) |-> !keep_q);
endmodule

// File: rtl/home_dir_ctrl.sv
module home_dir_ctrl #(
    parameter int NODE_W = 8,
    parameter int IDX_W  = 6,
    parameter int DATA_W = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [NODE_W-1:0] req_node,
    input  logic [IDX_W-1:0]  req_line,
    output logic              mem_req,
    output logic [IDX_W-1:0]  mem_line,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              rcl_valid,
    input  logic              rcl_ready,
    output logic [NODE_W-1:0] rcl_node,
    output logic [IDX_W-1:0]  rcl_line,
    input  logic              rcl_ack_valid,
    input  logic [DATA_W-1:0] rcl_ack_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [NODE_W-1:0] rsp_node,
    output logic [IDX_W-1:0]  rsp_line,
    output logic [DATA_W-1:0] rsp_data
);
    logic              ent_cached, ld_mem, ld_ack, wr_en;
    logic [NODE_W-1:0] ent_owner, cur_node;
    logic [IDX_W-1:0]  cur_line;

    hdc_fsm #(.NODE_W(NODE_W), .IDX_W(IDX_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_node(req_node), .req_line(req_line),
        .ent_cached(ent_cached), .ent_owner(ent_owner),
        .mem_req(mem_req), .mem_rsp_valid(mem_rsp_valid),
        .rcl_valid(rcl_valid), .rcl_ready(rcl_ready), .rcl_node(rcl_node),
        .rcl_ack_valid(rcl_ack_valid),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .cur_node(cur_node), .cur_line(cur_line),
        .ld_mem(ld_mem), .ld_ack(ld_ack), .wr_en(wr_en)
    );

    hdc_dir_table #(.NODE_W(NODE_W), .IDX_W(IDX_W)) u_dir (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(cur_line), .rd_cached(ent_cached), .rd_owner(ent_owner),
        .wr_en(wr_en), .wr_idx(cur_line), .wr_owner(cur_node)
    );

    hdc_line_buf #(.DATA_W(DATA_W)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .ld_mem(ld_mem), .mem_data(mem_rsp_data),
        .ld_ack(ld_ack), .ack_data(rcl_ack_data),
        .data_o(rsp_data)
    );

    assign mem_line = cur_line;
    assign rcl_line = cur_line;
    assign rsp_node = cur_node;
    assign rsp_line = cur_line;
endmodule

// File: tb/tb_home_dir_ctrl.sv
`timescale 1ns/1ps
module tb_home_dir_ctrl;
    localparam int NODE_W = 8;
    localparam int IDX_W  = 6;
    localparam int DATA_W = 512;
    localparam int DEPTH  = 1 << IDX_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready;
    logic [NODE_W-1:0] req_node = '0;
    logic [IDX_W-1:0]  req_line = '0;
    logic mem_req, mem_rsp_valid = 1'b0;
    logic [IDX_W-1:0]  mem_line;
    logic [DATA_W-1:0] mem_rsp_data = '0;
    logic rcl_valid, rcl_ready = 1'b0, rcl_ack_valid = 1'b0;
    logic [NODE_W-1:0] rcl_node;
    logic [IDX_W-1:0]  rcl_line;
    logic [DATA_W-1:0] rcl_ack_data = '0;
    logic rsp_valid, rsp_ready = 1'b0;
    logic [NODE_W-1:0] rsp_node;
    logic [IDX_W-1:0]  rsp_line;
    logic [DATA_W-1:0] rsp_data;

    always #2.5 clk = ~clk;

    home_dir_ctrl #(.NODE_W(NODE_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) dut (.*);

    int checks = 0, fails = 0;
    bit done = 1'b0;
    int mem_cnt = 0, rcl_cnt = 0;
    logic [IDX_W-1:0]  mem_last;
    logic [NODE_W-1:0] rcl_last_node;
    logic [IDX_W-1:0]  rcl_last_line;
    bit               m_cached [DEPTH];
    logic [NODE_W-1:0] m_owner [DEPTH];

    function automatic logic [DATA_W-1:0] mem_pat(logic [IDX_W-1:0] l);
        return {16{32'hA500_0000 ^ {26'd0, l}}};
    endfunction
    function automatic logic [DATA_W-1:0] ack_pat(logic [NODE_W-1:0] n, logic [IDX_W-1:0] l);
        return {16{32'h5C00_0000 | {16'd0, n, 2'b00, l}}};
    endfunction

    task automatic chk(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // memory model
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req) begin
                mem_cnt++;
                mem_last = mem_line;
                repeat ($urandom % 3) @(negedge clk);
                mem_rsp_data  = mem_pat(mem_line);
                mem_rsp_valid = 1'b1;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
            end
        end
    end

    // holder model
    initial begin
        forever begin
            @(negedge clk);
            if (rcl_valid) begin
                logic [NODE_W-1:0] n0;
                logic [IDX_W-1:0]  l0;
                rcl_cnt++;
                n0 = rcl_node;
                l0 = rcl_line;
                rcl_last_node = n0;
                rcl_last_line = l0;
                repeat ($urandom % 3) begin
                    @(negedge clk);
                    chk("R8", {rcl_valid, rcl_node, rcl_line}, {1'b1, n0, l0}, "recall held");
                end
                rcl_ready = 1'b1;
                @(negedge clk);
                rcl_ready = 1'b0;
                chk("R8", rcl_valid, 1'b0, "recall dropped");
                repeat ($urandom % 3) @(negedge clk);
                rcl_ack_data  = ack_pat(n0, l0);
                rcl_ack_valid = 1'b1;
                @(negedge clk);
                rcl_ack_valid = 1'b0;
            end
        end
    end

    task automatic do_req(logic [NODE_W-1:0] n, logic [IDX_W-1:0] l, string tag);
        int m0, r0, stall;
        bit exp_rcl;
        logic [NODE_W-1:0] holder;
        logic [DATA_W-1:0] exp_data;
        exp_rcl = m_cached[l] && (m_owner[l] != n);
        holder  = m_owner[l];
        exp_data = exp_rcl ? ack_pat(holder, l) : mem_pat(l);
        m0 = mem_cnt;
        r0 = rcl_cnt;
        req_node  = n;
        req_line  = l;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid) begin
            chk("R7", req_ready, 1'b0, "busy hold-off");
            @(negedge clk);
        end
        stall = $urandom % 3;
        repeat (stall) begin
            @(negedge clk);
            chk("R7", {rsp_valid, rsp_node, rsp_line, req_ready}, {1'b1, n, l, 1'b0}, "reply held");
        end
        chk(tag, rsp_node, n, "reply node");
        chk(tag, rsp_line, l, "reply line");
        chk(tag, rsp_data, exp_data, "reply data");
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk("R7", {rsp_valid, req_ready}, 2'b00, "update cycle");
        @(negedge clk);
        chk("R7", req_ready, 1'b1, "ready after update");
        if (exp_rcl) begin
            chk("R4", rcl_cnt - r0, 1, "one recall");
            chk("R4", mem_cnt - m0, 0, "no memory read");
            chk(tag, rcl_last_node, holder, "recall node");
            chk("R4", rcl_last_line, l, "recall line");
        end else begin
            chk(tag, rcl_cnt - r0, 0, "no recall");
            chk("R2", mem_cnt - m0, 1, "one memory read");
            chk("R2", mem_last, l, "memory line");
        end
        m_cached[l] = 1'b1;
        m_owner[l]  = n;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) begin
            m_cached[i] = 1'b0;
            m_owner[i]  = '0;
        end
        repeat (4) @(negedge clk);
        chk("R1", {req_ready, mem_req, rcl_valid, rsp_valid}, 4'b1000, "reset outputs");
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", {req_ready, mem_req, rcl_valid, rsp_valid}, 4'b1000, "idle outputs");
        // directed corner cases
        do_req(8'd255, 6'd63, "R1");   // top index, top node, uncached
        do_req(8'd0,   6'd0,  "R2");   // first index
        do_req(8'd7,   6'd63, "R3");   // recall from 255
        do_req(8'd9,   6'd63, "R5");   // recall from 7
        do_req(8'd9,   6'd63, "R6");   // same owner: memory read
        do_req(8'd1,   6'd63, "R6");   // still recalls from 9
        do_req(8'd1,   6'd0,  "R4");   // recall from 0
        // random mix
        for (int k = 0; k < 300; k++) begin
            logic [NODE_W-1:0] n;
            int pick;
            pick = $urandom % 5;
            n = (pick == 4) ? 8'd255 : NODE_W'(pick);
            do_req(n, IDX_W'($urandom % 8), "R4");
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule